// File: doc/BRIEF.md
# Five-Stage Pipeline Stall Controller with Shared Memory Port

This block is the control path of an in-order instruction pipeline with five stages: fetch, decode, operand fetch, execute and write-back. Each stage holds a valid bit and an instruction tag. When nothing is in the way, every valid instruction moves one stage forward on each clock edge. A new instruction is taken into the fetch stage on any cycle where the front end is able to accept it.

Instruction fetch and operand fetch use the same single memory port. Suppose the instruction in operand fetch needs memory while the fetch stage also holds an instruction. The controller then gives the port to operand fetch. It freezes the fetch and decode stages and sends an empty slot (a bubble) into operand fetch. The bubble travels down the pipe like an instruction but never causes a write-back. The controller also keeps a counter of retired instructions, so throughput can be checked against the fill-plus-stream rule.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stage valid bit, the retired counter and the memory grant (grant reads 2'b00).
- R2: With no conflict, each stage takes the contents of the stage before it on every edge, and the fetch stage takes `req_valid`/`req_tag`/`req_mem`. `req_ready` is 1 and the offered request is consumed.
- R3: With no stalls, n instructions offered back to back from edge 1 reach write-back at edges 5 through n+4, which is k+n-1 for k=5.
- R4: A conflict exists when the fetch stage is valid and the operand-fetch stage (stage index 2) is valid with its memory flag set. In that cycle `mem_grant` is 2'b10 and `req_ready` is 0.
- R5: On a conflict edge, the fetch and decode stages keep their valid bits and tags. Execute takes the operand-fetch instruction, and operand fetch becomes a bubble (valid 0). A conflict never occurs on two consecutive cycles.
- R6: A bubble never raises `wb_en`. `wb_en` is high only in a cycle where a real instruction sits in write-back, and `wb_tag` is then that instruction's tag.
- R7: A memory-using instruction in operand fetch causes no stall when the fetch stage is empty.
- R8: `mem_grant` encoding: 2'b00 means idle, 2'b01 means the fetch stage is valid and granted, 2'b10 means operand fetch is granted. 2'b11 never occurs.
- R9: `retire_cnt` increments by one, modulo 2^CNT_W, after every cycle in which `wb_en` is high.
- R10: Instructions leave write-back in the order they were accepted, each with its tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A new instruction is offered to fetch |
| req_tag | input | TAG_W | Tag of the offered instruction |
| req_mem | input | 1 | Offered instruction reads memory in operand fetch |
| req_ready | output | 1 | Offered instruction is taken at the next edge |
| stage_valid | output | 5 | Valid bit per stage, bit 0 = fetch ... bit 4 = write-back |
| stage_tag | output | 5*TAG_W | Tag per stage, stage i at bits [i*TAG_W +: TAG_W] |
| mem_grant | output | 2 | Memory port owner this cycle |
| wb_en | output | 1 | Write-back enable for the instruction in the last stage |
| wb_tag | output | TAG_W | Tag of the instruction in write-back |
| retire_cnt | output | CNT_W | Number of retired instructions |

## Verification
An instruction offered before edge e is in fetch after e, in decode after e+1 and in operand fetch after e+2. It reaches write-back at e+4 when no stall intervenes, and every stall in front of it adds exactly one edge. `req_ready` and `mem_grant` are combinational from the stage state, so they belong to the cycle after the edge that formed that state. The bench drives inputs on the falling edge and reads `req_ready` and `mem_grant` just after. It numbers rising edges from the first offered request and samples one nanosecond after each one. Each instruction's write-back edge, together with stage snapshots and grant values at chosen edges, is compared against hand-derived values for that scenario.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;

    localparam int NUM_STAGES = 5;

    typedef enum logic [2:0] {
        STG_FETCH   = 3'd0,
        STG_DECODE  = 3'd1,
        STG_OPFETCH = 3'd2,
        STG_EXEC    = 3'd3,
        STG_WRITE   = 3'd4
    } stage_e;

    typedef enum logic [1:0] {
        GNT_IDLE  = 2'b00,
        GNT_FETCH = 2'b01,
        GNT_OPER  = 2'b10
    } grant_e;

    typedef enum logic [1:0] {
        ACT_LOAD   = 2'd0,
        ACT_HOLD   = 2'd1,
        ACT_BUBBLE = 2'd2
    } slot_act_e;

    // Memory port clash between the front fetch and operand fetch
    function automatic logic port_clash(input logic fetch_busy,
                                        input logic oper_busy,
                                        input logic oper_mem);
        return fetch_busy && oper_busy && oper_mem;
    endfunction

    // What a stage does on the next edge, given its position and the stall
    function automatic slot_act_e slot_action(input int idx, input logic stall);
        if (!stall)
            return ACT_LOAD;
        if (idx < int'(STG_OPFETCH))
            return ACT_HOLD;
        if (idx == int'(STG_OPFETCH))
            return ACT_BUBBLE;
        return ACT_LOAD;
    endfunction

endpackage

// File: rtl/pipe_slot_reg.sv
module pipe_slot_reg
    import pipe_ctl_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_act_e        act,
    input  logic             vld_d,
    input  logic [PAY_W-1:0] pay_d,
    output logic             vld_q,
    output logic [PAY_W-1:0] pay_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pay_q <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    vld_q <= vld_d;
                    pay_q <= pay_d;
                end
                ACT_BUBBLE: begin
                    vld_q <= 1'b0;
                    pay_q <= '0;
                end
                default: begin
                    vld_q <= vld_q;
                    pay_q <= pay_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/pipe_port_arbiter.sv
module pipe_port_arbiter
    import pipe_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fetch_valid,
    input  logic       oper_valid,
    input  logic       oper_mem,
    output logic       stall,
    output logic [1:0] grant
);

    grant_e gnt;

    always_comb begin
        stall = port_clash(fetch_valid, oper_valid, oper_mem);
        if (oper_valid && oper_mem)
            gnt = GNT_OPER;
        else if (fetch_valid)
            gnt = GNT_FETCH;
        else
            gnt = GNT_IDLE;
    end

    assign grant = gnt;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R8

    AST_STALL_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall); // R5

endmodule

// File: rtl/pipe_retire_counter.sv
module pipe_retire_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (retire)
            count <= count + 1'b1;
    end

    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
        retire |=> count == $past(count) + 1'b1); // R9

    AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(count)); // R9

endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl
    import pipe_ctl_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic                        req_mem,
    output logic                        req_ready,
    output logic [NUM_STAGES-1:0]       stage_valid,
    output logic [NUM_STAGES*TAG_W-1:0] stage_tag,
    output logic [1:0]                  mem_grant,
    output logic                        wb_en,
    output logic [TAG_W-1:0]            wb_tag,
    output logic [CNT_W-1:0]            retire_cnt
);

    localparam int FET = int'(STG_FETCH);
    localparam int DEC = int'(STG_DECODE);
    localparam int OPF = int'(STG_OPFETCH);
    localparam int EXE = int'(STG_EXEC);
    localparam int WRB = int'(STG_WRITE);

    logic [NUM_STAGES-1:0] vld_q;
    logic [TAG_W-1:0]      tag_q [NUM_STAGES];
    logic                  mem_q [OPF+1];
    slot_act_e             act   [NUM_STAGES];
    logic                  stall;

    pipe_port_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (vld_q[FET]),
        .oper_valid  (vld_q[OPF]),
        .oper_mem    (mem_q[OPF]),
        .stall       (stall),
        .grant       (mem_grant)
    );

    always_comb begin
        for (int i = 0; i < NUM_STAGES; i++)
            act[i] = slot_action(i, stall);
    end

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        localparam bit KEEP_MEM = (i <= OPF);
        localparam int PW       = KEEP_MEM ? TAG_W + 1 : TAG_W;

        logic          vld_d;
        logic [PW-1:0] pay_d;
        logic [PW-1:0] pay_q;

        if (i == 0) begin : g_head
            assign vld_d = req_valid;
            assign pay_d = {req_mem, req_tag};
        end else if (KEEP_MEM) begin : g_mid
            assign vld_d = vld_q[i-1];
            assign pay_d = {mem_q[i-1], tag_q[i-1]};
        end else begin : g_tail
            assign vld_d = vld_q[i-1];
            assign pay_d = tag_q[i-1];
        end

        pipe_slot_reg #(.PAY_W(PW)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .act   (act[i]),
            .vld_d (vld_d),
            .pay_d (pay_d),
            .vld_q (vld_q[i]),
            .pay_q (pay_q)
        );

        assign tag_q[i] = pay_q[TAG_W-1:0];
        assign stage_tag[i*TAG_W +: TAG_W] = tag_q[i];

        if (KEEP_MEM) begin : g_mem
            assign mem_q[i] = pay_q[TAG_W];
        end
    end

    pipe_retire_counter #(.CNT_W(CNT_W)) u_retire (
        .clk    (clk),
        .rst    (rst),
        .retire (vld_q[WRB]),
        .count  (retire_cnt)
    );

    assign req_ready   = !stall;
    assign stage_valid = vld_q;
    assign wb_en       = vld_q[WRB];
    assign wb_tag      = tag_q[WRB];

    AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(vld_q[DEC:FET]) && tag_q[FET] == $past(tag_q[FET])
                  && tag_q[DEC] == $past(tag_q[DEC])); // R5

    AST_OPF_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !vld_q[OPF]); // R5

    AST_EXEC_TAKES_OPF: assert property (@(posedge clk) disable iff (rst)
        stall |=> vld_q[EXE] && tag_q[EXE] == $past(tag_q[OPF])); // R5

    AST_FLOW_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !stall |=> vld_q[OPF] == $past(vld_q[DEC]) && vld_q[FET] == $past(req_valid)); // R2

    AST_BUBBLE_NEVER_WRITES: assert property (@(posedge clk) disable iff (rst)
        stall |=> ##2 !wb_en); // R6

    AST_IDLE_FETCH_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !vld_q[FET] |-> req_ready); // R7

endmodule

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb;

    localparam int TAG_W = 8;
    localparam int CNT_W = 16;
    localparam int NSTG  = 5;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic [TAG_W-1:0]        req_tag = '0;
    logic                    req_mem = 1'b0;
    logic                    req_ready;
    logic [NSTG-1:0]         stage_valid;
    logic [NSTG*TAG_W-1:0]   stage_tag;
    logic [1:0]              mem_grant;
    logic                    wb_en;
    logic [TAG_W-1:0]        wb_tag;
    logic [CNT_W-1:0]        retire_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pipe_stall_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_tag     (req_tag),
        .req_mem     (req_mem),
        .req_ready   (req_ready),
        .stage_valid (stage_valid),
        .stage_tag   (stage_tag),
        .mem_grant   (mem_grant),
        .wb_en       (wb_en),
        .wb_tag      (wb_tag),
        .retire_cnt  (retire_cnt)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer n instructions back to back; tags 1..n, memory flags from mmask.
    // exp_wb byte j = edge at which tag j+1 is in write-back.
    // snap_t byte i = expected tag of stage i after edge snap_e (valid stages only).
    task automatic run_seq(input string name, input int n, input logic [7:0] mmask,
                           input logic [63:0] exp_wb,
                           input int snap_e, input logic [4:0] snap_v, input logic [39:0] snap_t,
                           input int g_e, input logic [1:0] g_exp, input logic g_rdy);
        int next = 0;
        logic acc;
        logic [63:0] got_wb = '0;
        logic [CNT_W-1:0] base = retire_cnt;
        for (int e = 1; e <= 24; e++) begin
            @(negedge clk);
            if (next < n) begin
                req_valid = 1'b1;
                req_tag   = TAG_W'(next + 1);
                req_mem   = mmask[next];
            end else begin
                req_valid = 1'b0;
                req_tag   = '0;
                req_mem   = 1'b0;
            end
            #1;
            if (e - 1 == g_e) begin
                chk("R4/R8", {name, " grant"}, 64'(mem_grant), 64'(g_exp));
                if (req_valid)
                    chk("R4", {name, " ready"}, 64'(req_ready), 64'(g_rdy));
            end
            acc = req_valid && req_ready;
            @(posedge clk);
            #1;
            if (acc) next++;
            if (wb_en) begin
                if (wb_tag >= 1 && int'(wb_tag) <= n)
                    got_wb[(int'(wb_tag) - 1)*8 +: 8] = 8'(e);
                else
                    chk("R6", {name, " wb of non-instruction tag"}, 64'(wb_tag), 64'd0);
            end
            if (e == snap_e) begin
                chk("R5", {name, " stage valid"}, 64'(stage_valid), 64'(snap_v));
                for (int s = 0; s < NSTG; s++)
                    if (snap_v[s])
                        chk("R5/R10", {name, " stage tag"},
                            64'(stage_tag[s*TAG_W +: TAG_W]), 64'(snap_t[s*8 +: 8]));
            end
        end
        req_valid = 1'b0;
        chk("R3/R10", {name, " write-back edges"}, got_wb, exp_wb);
        chk("R9", {name, " retired count"}, 64'(retire_cnt), 64'(CNT_W'(base + CNT_W'(n))));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "reset valid", 64'(stage_valid), 64'd0);
        chk("R1", "reset retire", 64'(retire_cnt), 64'd0);
        chk("R1", "reset grant", 64'(mem_grant), 64'd0);
        chk("R6", "reset wb_en", 64'(wb_en), 64'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R2/R3: plain stream of six, no memory users; first out at edge 5, last at 10
    task automatic t_stream;
        run_seq("stream", 6, 8'h00, 64'h00000A0908070605,
                3, 5'b00111, 40'h0000010203, 3, 2'b01, 1'b1);
    endtask

    // R4/R5: first instruction reads memory while instruction 3 is being fetched
    task automatic t_mem_first;
        run_seq("mem_first", 4, 8'h01, 64'h0000000009080705,
                4, 5'b01011, 40'h0001000203, 3, 2'b10, 1'b0);
    endtask

    // R7: memory user in operand fetch with fetch stage empty: no stall
    task automatic t_mem_last;
        run_seq("mem_last", 4, 8'h08, 64'h0000000008070605,
                6, 5'b11100, 40'h0203040000, 6, 2'b10, 1'b1);
    endtask

    // R5/R6: two memory users back to back cost two bubbles
    task automatic t_two_mem;
        run_seq("two_mem", 4, 8'h03, 64'h000000000A090705,
                6, 5'b01011, 40'h0002000304, 5, 2'b10, 1'b0);
    endtask

    // R1: reset in the middle of traffic clears all state
    task automatic t_mid_reset;
        for (int e = 0; e < 3; e++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_tag   = TAG_W'(8'h40 + e);
            req_mem   = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "pipe busy before reset", 64'(stage_valid != 0), 64'd1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "mid reset valid", 64'(stage_valid), 64'd0);
        chk("R1", "mid reset retire", 64'(retire_cnt), 64'd0);
        chk("R1", "mid reset grant", 64'(mem_grant), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R6", "no write-back after reset", 64'(wb_en), 64'd0);
    endtask

    initial begin
        t_reset();
        t_stream();
        t_mem_first();
        t_mem_last();
        t_two_mem();
        t_mid_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule